// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the fetch side of an Ethernet transmit path. Software builds a ring of 16-byte descriptors in memory, each pointing at one buffer. A descriptor is given to hardware by setting its ownership bit. The engine reads descriptors over a simple memory port, streams the referenced buffer one byte per accepted cycle toward the MAC transmitter, and then gives the descriptor back by rewriting its first word with ownership cleared. It then moves to the next slot, or back to the ring base when the descriptor carries the end-of-ring flag.

Software first programs the ring base while transmit DMA is disabled. Enabling DMA points the engine at that base. From then on, a poll-demand strobe wakes the engine. It keeps walking the ring until it reads a descriptor that software still owns, and then waits for the next poll. The memory port returns read data one cycle after a request. Buffers start on a 4-byte boundary, and bytes are packed little-endian within each word.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset, and for as long as `dma_en` is low, the engine issues no memory request and presents no byte. A poll strobe given while `dma_en` is low has no effect.
- R2: A `base_wr` strobe captures `base_wdata` with bits [3:0] forced to zero. The 0-to-1 edge of `dma_en` sets the current descriptor pointer to that base. No descriptor is fetched until a poll strobe arrives.
- R3: A poll strobe in idle makes the engine read word 0 at the current pointer. If bit 31 (ownership) is clear, it reads nothing more and returns to idle without advancing. An owned descriptor further on stays untouched.
- R4: For an owned descriptor, the engine reads the buffer address from word 3 (offset 12). It never reads words 1 and 2. It streams word0[13:0] bytes, where byte k is bits [8*(k%4)+7 : 8*(k%4)] of the word at buffer+4*(k/4).
- R5: After the last byte, the engine writes word 0 back to the same address. Bit 31 is cleared and every other bit, including bit 15, is unchanged.
- R6: After write-back, the pointer goes to the ring base if word0 bit 15 is set, and to pointer+16 otherwise. The engine then fetches that descriptor without a new poll.
- R7: `tx_sof` is high with the first byte of a descriptor whose bit 29 is set. `tx_eof` is high with the last byte of a descriptor whose bit 28 is set. A frame split over several descriptors shows one of each.
- R8: `frame_done` pulses for one cycle, in the write-back cycle, only for a descriptor whose bit 28 is set.
- R9: A descriptor with a byte count of zero produces no byte. It is still written back and the pointer still advances.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| base_wr | input | 1 | ring base write strobe |
| base_wdata | input | AW | ring base value |
| dma_en | input | 1 | transmit DMA enable level |
| poll_wr | input | 1 | poll-demand strobe |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | write (1) or read (0) |
| mem_addr | output | AW | byte address, word aligned |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, valid the cycle after a read request |
| tx_valid | output | 1 | byte available |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | byte |
| tx_sof | output | 1 | first byte of a frame |
| tx_eof | output | 1 | last byte of a frame |
| frame_done | output | 1 | frame descriptor returned to software |

## Verification
The bench builds small rings in a behavioural memory and goes after these cases:
- **Wrap through the end-of-ring flag.** A trap descriptor is placed just past the last slot. An engine that wrapped by count or ignored the flag would transmit it.
- **Stall at an unowned slot.** An owned descriptor follows the stalled slot. An engine that skipped ahead would send its bytes.
- **Write-back.** A sloppy write-back would lose the end-of-ring bit or never clear ownership, and this shows up in memory.
- **Split frames, zero-length buffers and back-pressure.** These expose misplaced markers, spurious completions, dropped or repeated bytes, and fetches made while disabled or before the first poll.

// File: rtl/txr_pkg.sv
package txr_pkg;
    // Descriptor word 0 layout (decoded by software, so positions are fixed)
    localparam int unsigned OWN_BIT   = 31;
    localparam int unsigned FIRST_BIT = 29;
    localparam int unsigned LAST_BIT  = 28;
    localparam int unsigned EOR_BIT   = 15;
    localparam int unsigned CNT_W     = 14;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned LANES     = WORD_W / 8;
    localparam int unsigned LANE_W    = $clog2(LANES);
    localparam int unsigned SLOT_BYTES = 16;
    localparam int unsigned BUFPTR_OFS = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_W0,
        ST_CAP_W0,
        ST_RD_W3,
        ST_CAP_W3,
        ST_RD_BUF,
        ST_CAP_BUF,
        ST_SEND,
        ST_WB
    } txr_state_e;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_in,
    input  logic          load,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] cur_o
);
    import txr_pkg::*;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] cur;
    } ptr_regs_t;

    ptr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (base_we) begin
            r_d.base = {base_in[AW-1:4], 4'b0000};
        end
        if (load) begin
            r_d.cur = r_q.base;
        end else if (step) begin
            r_d.cur = wrap ? r_q.base : r_q.cur + AW'(SLOT_BYTES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_o = r_q.cur;
endmodule

// File: rtl/tx_byte_pick.sv
module tx_byte_pick
    import txr_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANE_W-1:0] sel_i,
    output logic [7:0]        byte_o
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lanes[sel_i];
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
    import txr_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          dma_en,
    input  logic          poll_wr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_sof,
    output logic          tx_eof,
    output logic          frame_done
);
    typedef struct packed {
        txr_state_e         st;
        logic [WORD_W-1:0]  w0;
        logic [AW-1:0]      bufp;
        logic [CNT_W-1:0]   left;
        logic [WORD_W-1:0]  word;
        logic [LANE_W-1:0]  lane;
        logic               sof_pend;
        logic               en;
    } eng_regs_t;

    eng_regs_t s_d, s_q;
    logic [AW-1:0] cur;
    logic          ptr_load, ptr_step, ptr_wrap;

    tx_ring_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_we (base_wr),
        .base_in (base_wdata),
        .load    (ptr_load),
        .step    (ptr_step),
        .wrap    (ptr_wrap),
        .cur_o   (cur)
    );

    tx_byte_pick u_pick (
        .word_i (s_q.word),
        .sel_i  (s_q.lane),
        .byte_o (tx_data)
    );

    always_comb begin
        s_d        = s_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur;
        mem_wdata  = '0;
        tx_valid   = 1'b0;
        tx_sof     = 1'b0;
        tx_eof     = 1'b0;
        frame_done = 1'b0;
        ptr_step   = 1'b0;
        ptr_wrap   = 1'b0;
        ptr_load   = dma_en && !s_q.en;
        s_d.en     = dma_en;

        unique case (s_q.st)
            ST_IDLE: begin
                if (poll_wr) s_d.st = ST_RD_W0;
            end
            ST_RD_W0: begin
                mem_req = 1'b1;
                s_d.st  = ST_CAP_W0;
            end
            ST_CAP_W0: begin
                s_d.w0 = mem_rdata;
                s_d.st = mem_rdata[OWN_BIT] ? ST_RD_W3 : ST_IDLE;
            end
            ST_RD_W3: begin
                mem_req  = 1'b1;
                mem_addr = cur + AW'(BUFPTR_OFS);
                s_d.st   = ST_CAP_W3;
            end
            ST_CAP_W3: begin
                s_d.bufp     = {mem_rdata[AW-1:2], 2'b00};
                s_d.left     = s_q.w0[CNT_W-1:0];
                s_d.lane     = '0;
                s_d.sof_pend = 1'b1;
                s_d.st       = (s_q.w0[CNT_W-1:0] == '0) ? ST_WB : ST_RD_BUF;
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = s_q.bufp;
                s_d.st   = ST_CAP_BUF;
            end
            ST_CAP_BUF: begin
                s_d.word = mem_rdata;
                s_d.st   = ST_SEND;
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_sof   = s_q.sof_pend && s_q.w0[FIRST_BIT];
                tx_eof   = (s_q.left == CNT_W'(1)) && s_q.w0[LAST_BIT];
                if (tx_ready) begin
                    s_d.sof_pend = 1'b0;
                    s_d.left     = s_q.left - CNT_W'(1);
                    s_d.lane     = s_q.lane + LANE_W'(1);
                    if (s_q.left == CNT_W'(1)) begin
                        s_d.st = ST_WB;
                    end else if (s_q.lane == LANE_W'(LANES - 1)) begin
                        s_d.bufp = s_q.bufp + AW'(LANES);
                        s_d.st   = ST_RD_BUF;
                    end
                end
            end
            ST_WB: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_wdata  = s_q.w0 & ~(WORD_W'(1) << OWN_BIT);
                frame_done = s_q.w0[LAST_BIT];
                ptr_step   = 1'b1;
                ptr_wrap   = s_q.w0[EOR_BIT];
                s_d.st     = ST_RD_W0;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (!dma_en) s_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_en,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_sof,
    input logic          frame_done
);
    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> (!mem_req && !tx_valid));

    // R5
    wb_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (!mem_wdata[31] && mem_addr[3:0] == 4'h0));

    // R8
    done_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (mem_req && mem_we));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && dma_en) |=> (tx_valid && $stable(tx_data)));

    // R7
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> tx_valid);
endmodule

bind tx_ring_dma txr_chk #(.AW(AW)) u_txr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en     (dma_en),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_sof     (tx_sof),
    .frame_done (frame_done)
);

// File: tb/tb_tx_ring_dma.sv
module tb_tx_ring_dma;
    localparam int AW = 32;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] FST = 32'h2000_0000;
    localparam logic [31:0] LST = 32'h1000_0000;
    localparam logic [31:0] EOR = 32'h0000_8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_wr = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic dma_en = 1'b0;
    logic poll_wr = 1'b0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic tx_valid, tx_sof, tx_eof, frame_done;
    logic tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic rdy_toggle = 1'b0;

    logic [31:0] mem [0:255];
    logic [7:0] got [0:63];
    logic [7:0] exp_b [0:63];
    int ng = 0, nsof = 0, neof = 0, ndone = 0, nreq = 0, nbad = 0;
    int tests = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    tx_ring_dma #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
        .dma_en(dma_en), .poll_wr(poll_wr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_eof(tx_eof), .frame_done(frame_done)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
        if (rdy_toggle) tx_ready <= ~tx_ready;
        else            tx_ready <= 1'b1;
    end

    always @(negedge clk) begin
        cyc++;
        if (tx_valid && tx_ready) begin
            if (ng < 64) got[ng] = tx_data;
            ng++;
            if (tx_sof) nsof++;
            if (tx_eof) neof++;
        end
        if (frame_done) ndone++;
        if (mem_req) nreq++;
        if (mem_req && !mem_we && mem_addr < 32'h200 &&
            (mem_addr[3:0] == 4'h4 || mem_addr[3:0] == 4'h8)) nbad++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, expv);
        end
    endtask

    task automatic clr_mon();
        ng = 0; nsof = 0; neof = 0; ndone = 0; nreq = 0;
    endtask

    task automatic fill_buf(input int addr, input int n, input int pos0, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            mem[(addr >> 2) + i / 4][8*(i%4) +: 8] = seed + 8'(i);
            exp_b[pos0 + i] = seed + 8'(i);
        end
    endtask

    task automatic put_desc(input int addr, input logic [31:0] w0, input int bufa);
        mem[addr >> 2]       = w0;
        mem[(addr >> 2) + 1] = 32'hDEAD_0001;
        mem[(addr >> 2) + 2] = 32'hDEAD_0002;
        mem[(addr >> 2) + 3] = bufa;
    endtask

    task automatic poll();
        @(negedge clk) poll_wr = 1'b1;
        @(negedge clk) poll_wr = 1'b0;
        repeat (150) @(negedge clk);
    endtask

    task automatic setup(input int base);
        @(negedge clk) dma_en = 1'b0;
        @(negedge clk) begin base_wr = 1'b1; base_wdata = base; end
        @(negedge clk) base_wr = 1'b0;
        dma_en = 1'b1;
        repeat (2) @(negedge clk);
        clr_mon();
    endtask

    task automatic cmp_bytes(input string tag, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (got[i] !== exp_b[i]) bad++;
        chk(ng == n && bad == 0, tag, ng, n);
    endtask

    task automatic t_reset();
        chk(!tx_valid && !mem_req && !frame_done, "R1 reset quiet",
            {tx_valid, mem_req, frame_done}, 0);
    endtask

    task automatic t_single();
        setup(32'h000);
        put_desc(32'h000, OWN | FST | LST | 32'd6, 32'h200);
        put_desc(32'h010, 32'h0, 32'h0);
        fill_buf(32'h200, 6, 0, 8'hA0);
        poll();
        cmp_bytes("R4 single buffer bytes", 6);
        chk(mem[0] == (FST | LST | 32'd6), "R5 writeback", mem[0], FST | LST | 32'd6);
        chk(nsof == 1 && neof == 1, "R7 markers single", {nsof, neof}, 2'b11);
        chk(ndone == 1, "R8 done single", ndone, 1);
    endtask

    task automatic t_multi();
        setup(32'h040);
        put_desc(32'h040, OWN | FST | 32'd3, 32'h240);
        put_desc(32'h050, OWN | LST | 32'd5, 32'h260);
        put_desc(32'h060, 32'h0, 32'h0);
        fill_buf(32'h240, 3, 0, 8'h11);
        fill_buf(32'h260, 5, 3, 8'h61);
        poll();
        cmp_bytes("R6 two segments bytes", 8);
        chk(nsof == 1 && neof == 1, "R7 markers split", nsof * 10 + neof, 11);
        chk(ndone == 1, "R8 one done per frame", ndone, 1);
        chk(mem[32'h040 >> 2] == (FST | 32'd3), "R5 first seg wb", mem[32'h040 >> 2], FST | 32'd3);
    endtask

    task automatic t_wrap();
        setup(32'h080);
        put_desc(32'h080, OWN | FST | LST | 32'd2, 32'h280);
        put_desc(32'h090, OWN | FST | LST | EOR | 32'd3, 32'h2A0);
        put_desc(32'h0A0, OWN | FST | LST | 32'd1, 32'h2C0);
        fill_buf(32'h280, 2, 0, 8'h10);
        fill_buf(32'h2A0, 3, 2, 8'h20);
        poll();
        cmp_bytes("R6 wrap no trap", 5);
        chk(ndone == 2, "R8 done count", ndone, 2);
        chk(mem[32'h090 >> 2] == (FST | LST | EOR | 32'd3), "R5 eor kept",
            mem[32'h090 >> 2], FST | LST | EOR | 32'd3);
        chk(mem[32'h0A0 >> 2][31], "R6 trap untouched", mem[32'h0A0 >> 2], OWN);
        clr_mon();
        put_desc(32'h080, OWN | FST | LST | 32'd4, 32'h2E0);
        fill_buf(32'h2E0, 4, 0, 8'h30);
        poll();
        cmp_bytes("R6 restart at base", 4);
    endtask

    task automatic t_stall();
        setup(32'h0C0);
        put_desc(32'h0C0, 32'h0, 32'h300);
        put_desc(32'h0D0, OWN | FST | LST | 32'd2, 32'h300);
        poll();
        chk(ng == 0 && nreq == 1, "R3 stall no skip", ng * 100 + nreq, 1);
        chk(mem[32'h0D0 >> 2][31], "R3 next still owned", mem[32'h0D0 >> 2], OWN);
    endtask

    task automatic t_zero();
        setup(32'h0E0);
        put_desc(32'h0E0, OWN | FST | LST | 32'd0, 32'h300);
        put_desc(32'h0F0, 32'h0, 32'h0);
        poll();
        chk(ng == 0, "R9 zero count no bytes", ng, 0);
        chk(ndone == 1 && mem[32'h0E0 >> 2] == (FST | LST), "R9 zero wb",
            mem[32'h0E0 >> 2], FST | LST);
        chk(nreq == 4, "R9 zero advance reads next", nreq, 4);
    endtask

    task automatic t_bp();
        setup(32'h100);
        put_desc(32'h100, OWN | FST | LST | 32'd9, 32'h320);
        put_desc(32'h110, 32'h0, 32'h0);
        fill_buf(32'h320, 9, 0, 8'h71);
        rdy_toggle = 1'b1;
        poll();
        rdy_toggle = 1'b0;
        cmp_bytes("R10 backpressure bytes", 9);
    endtask

    task automatic t_dis();
        @(negedge clk) dma_en = 1'b0;
        @(negedge clk) begin base_wr = 1'b1; base_wdata = 32'h127; end
        @(negedge clk) base_wr = 1'b0;
        put_desc(32'h120, OWN | FST | LST | 32'd2, 32'h340);
        put_desc(32'h130, 32'h0, 32'h0);
        fill_buf(32'h340, 2, 0, 8'h50);
        clr_mon();
        poll();
        chk(nreq == 0 && ng == 0, "R1 poll ignored disabled", nreq, 0);
        @(negedge clk) dma_en = 1'b1;
        repeat (30) @(negedge clk);
        chk(nreq == 0, "R2 no fetch before poll", nreq, 0);
        poll();
        cmp_bytes("R2 base aligned start", 2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_wrap();
        t_stall();
        t_zero();
        t_bp();
        t_dis();
        chk(nbad == 0, "R4 words 1 and 2 never read", nbad, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule